// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches up to 23 synchronized input pins, arranged as three groups of eight pin positions, and turns any logic transition on them into one interrupt request per group. Each pin has its own mask bit, so software picks which pins take part. A transition in either direction on a pin whose mask bit is set marks its group as pending. The pending flag is sticky: it stays set until the group's acknowledge input is pulsed or until software writes a 1 to that flag bit. Working out which pin within the group moved is left to software, which can compare the pins against a value it saved earlier.

A pending flag becomes a request only after two enables: its own group enable, then the global interrupt enable. A flag can be set while either enable is off. The request appears as soon as both enables are on. All configuration goes through a small register bus. The bus takes a single-cycle write strobe and reads combinationally.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, every mask bit, group enable, pending flag and the global enable is 0, every register reads 0 and irq_o is 0.
- R2: Registers at addresses 0, 1 and 2 hold the masks for groups 0, 1 and 2, with bit k of group g guarding pin g*8+k. Group 1 has only seven pins: mask bit 7 at address 1 cannot be set, reads 0, and pin 15 never sets a flag.
- R3: Address 3 holds the group enables in bits 2..0, with bit g for group g. Bits 7..3 ignore writes and read 0.
- R4: A rising or a falling transition on a pin whose mask bit is 1 sets its group's pending flag at the next clock edge. Flag g reads at address 4, bit g.
- R5: A transition on a pin whose mask bit is 0 sets no flag.
- R6: irq_o[g] is 1 exactly when flag g, group enable g and the global enable are all 1. The groups are independent.
- R7: While the global enable is 0, irq_o is 0 whatever the other enables are. Transitions still set flags, and the requests appear on the cycle after the global enable is written back to 1.
- R8: A pending flag is cleared by ack_i[g] or by writing 1 to bit g at address 4. Writing 0 to a flag bit leaves it unchanged.
- R9: If a new qualifying transition arrives in the same cycle as a clear of that group's flag, the flag stays set.
- R10: Address 5 holds the global enable in bit 0. Bits 7..1 read 0.
- R11: A flag is set even while its group enable is 0, and the request appears once the group enable is written to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| pins_i | input | 24 | Synchronized pin levels, group g at bits g*8+7..g*8 |
| ack_i | input | 3 | Per-group acknowledge, clears the pending flag |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The assertions assume that pins_i is already synchronous to clk_i. They also assume that ack_i and the write strobe are driven between edges and sampled only at the rising edge. The properties on flag clearing and on quiet pins further assume that a cycle with unchanged pins produces no transition. The bench drives every input on the falling edge, changes pins only through whole-cycle steps, and includes cycles in which a clear and a transition arrive together, so that the set-over-clear priority is exercised.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int unsigned GROUPS_DEF = 3;
  localparam int unsigned WIDTH_DEF  = 8;
  // register slots after the mask registers
  localparam int unsigned SLOT_CTRL = 0;
  localparam int unsigned SLOT_FLAG = 1;
  localparam int unsigned SLOT_GLB  = 2;
  localparam int unsigned SLOTS     = 3;
endpackage

// File: rtl/pcirq_regs.sv
module pcirq_regs
  import pcirq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned WIDTH  = WIDTH_DEF,
  parameter int unsigned ADDR_W = 3,
  parameter logic [GROUPS*WIDTH-1:0] PIN_VALID = '1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WIDTH-1:0]          wdata_i,
  input  logic [GROUPS-1:0]         flags_i,
  output logic [GROUPS*WIDTH-1:0]   mask_o,
  output logic [GROUPS-1:0]         grp_en_o,
  output logic                      glb_en_o,
  output logic [GROUPS-1:0]         w1c_o,
  output logic [WIDTH-1:0]          rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(GROUPS + SLOT_CTRL);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(GROUPS + SLOT_FLAG);
  localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(GROUPS + SLOT_GLB);

  for (genvar g = 0; g < GROUPS; g++) begin : g_mask
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) q <= wdata_i & PIN_VALID[g*WIDTH +: WIDTH];
    end
    assign mask_o[g*WIDTH +: WIDTH] = q;
  end

  logic [GROUPS-1:0] grp_en_q;
  logic              glb_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en_q <= '0;
      glb_en_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) grp_en_q <= wdata_i[GROUPS-1:0];
      if (addr_i == A_GLB)  glb_en_q <= wdata_i[0];
    end
  end

  assign grp_en_o = grp_en_q;
  assign glb_en_o = glb_en_q;
  assign w1c_o    = (we_i && addr_i == A_FLAG) ? wdata_i[GROUPS-1:0] : '0;

  always_comb begin
    rd_data_o = '0;
    if (int'(addr_i) < GROUPS) rd_data_o = mask_o[int'(addr_i)*WIDTH +: WIDTH];
    else if (addr_i == A_CTRL) rd_data_o[GROUPS-1:0] = grp_en_q;
    else if (addr_i == A_FLAG) rd_data_o[GROUPS-1:0] = flags_i;
    else if (addr_i == A_GLB)  rd_data_o[0] = glb_en_q;
  end
endmodule

// File: rtl/pcirq_detect.sv
module pcirq_detect
  import pcirq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned WIDTH  = WIDTH_DEF,
  localparam int unsigned NPINS = GROUPS * WIDTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [NPINS-1:0]  mask_i,
  output logic [GROUPS-1:0] grp_chg_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  // either-edge detect, masked per pin
  assign chg = (pins_i ^ prev_q) & mask_i;

  for (genvar g = 0; g < GROUPS; g++) begin : g_or
    assign grp_chg_o[g] = |chg[g*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/pcirq_flags.sv
module pcirq_flags
  import pcirq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GROUPS-1:0] set_i,
  input  logic [GROUPS-1:0] clr_i,
  input  logic [GROUPS-1:0] grp_en_i,
  input  logic              glb_en_i,
  output logic [GROUPS-1:0] flags_o,
  output logic [GROUPS-1:0] irq_o
);
  logic [GROUPS-1:0] flags_q;

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = flags_q & grp_en_i & {GROUPS{glb_en_i}};
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned WIDTH  = WIDTH_DEF,
  parameter logic [GROUPS*WIDTH-1:0] PIN_VALID = 24'hFF_7F_FF,
  localparam int unsigned NPINS  = GROUPS * WIDTH,
  localparam int unsigned ADDR_W = $clog2(GROUPS + SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rd_data_o,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [GROUPS-1:0] ack_i,
  output logic [GROUPS-1:0] irq_o
);
  logic [NPINS-1:0]  mask_w;
  logic [GROUPS-1:0] grp_en_w;
  logic              glb_en_w;
  logic [GROUPS-1:0] w1c_w;
  logic [GROUPS-1:0] flags_w;
  logic [GROUPS-1:0] chg_w;

  pcirq_regs #(
    .GROUPS(GROUPS), .WIDTH(WIDTH), .ADDR_W(ADDR_W), .PIN_VALID(PIN_VALID)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .flags_i(flags_w), .mask_o(mask_w),
    .grp_en_o(grp_en_w), .glb_en_o(glb_en_w), .w1c_o(w1c_w),
    .rd_data_o(rd_data_o)
  );

  pcirq_detect #(.GROUPS(GROUPS), .WIDTH(WIDTH)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .mask_i(mask_w),
    .grp_chg_o(chg_w)
  );

  pcirq_flags #(.GROUPS(GROUPS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(chg_w), .clr_i(ack_i | w1c_w),
    .grp_en_i(grp_en_w), .glb_en_i(glb_en_w), .flags_o(flags_w),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk
  import pcirq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned WIDTH  = WIDTH_DEF,
  parameter int unsigned ADDR_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [WIDTH-1:0]        wdata_i,
  input logic [WIDTH-1:0]        rd_data_o,
  input logic [GROUPS*WIDTH-1:0] pins_i,
  input logic [GROUPS-1:0]       ack_i,
  input logic [GROUPS-1:0]       irq_o,
  input logic [GROUPS-1:0]       flags,
  input logic                    glb_en
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(GROUPS + SLOT_CTRL);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(GROUPS + SLOT_FLAG);

  a_r7_global_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |-> irq_o == '0);

  a_r3_ctrl_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_CTRL |-> rd_data_o[WIDTH-1:GROUPS] == '0);

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags[g] && !ack_i[g] && !(wr_en_i && addr_i == A_FLAG && wdata_i[g]) |=> flags[g]);

    a_r5_quiet_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flags[g] && $stable(pins_i) |=> !flags[g]);

    a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[g] && $stable(pins_i) |=> !flags[g]);
  end
endmodule

bind pin_change_irq pin_change_irq_chk #(
  .GROUPS(GROUPS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rd_data_o(rd_data_o), .pins_i(pins_i), .ack_i(ack_i),
  .irq_o(irq_o), .flags(flags_w), .glb_en(glb_en_w)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic [23:0] pins_i = '0;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pin_change_irq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o), .pins_i(pins_i),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  // behavioural reference
  logic [23:0] m_mask, m_prev;
  logic [2:0]  m_flag, m_gen;
  logic        m_glb;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = '0; m_prev = '0; m_flag = '0; m_gen = '0; m_glb = 1'b0;
    end else begin
      logic [2:0] hit, clr;
      hit = '0;
      for (int p = 0; p < 24; p++)
        if (m_mask[p] && pins_i[p] != m_prev[p]) hit[p/8] = 1'b1;
      clr = ack_i | ((wr_en_i && addr_i == 3'd4) ? wdata_i[2:0] : 3'b000);
      m_flag = (m_flag & ~clr) | hit;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: m_mask[7:0]   = wdata_i;
          3'd1: m_mask[15:8]  = wdata_i & 8'h7F;
          3'd2: m_mask[23:16] = wdata_i;
          3'd3: m_gen = wdata_i[2:0];
          3'd5: m_glb = wdata_i[0];
          default: ;
        endcase
      end
      m_prev = pins_i;
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mask[7:0];
      3'd1: return m_mask[15:8];
      3'd2: return m_mask[23:16];
      3'd3: return {5'b0, m_gen};
      3'd4: return {5'b0, m_flag};
      3'd5: return {7'b0, m_glb};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock; compare against the model on the falling edge
  task automatic tick();
    @(negedge clk_i);
    chk("R6 irq vs model", {5'b0, irq_o}, {5'b0, m_flag & m_gen & {3{m_glb}}});
    chk("R2 read vs model", rd_data_o, m_read(addr_i));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic irq_chk(input logic [2:0] exp, input string tag);
    chk(tag, {5'b0, irq_o}, {5'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    irq_chk(3'b000, "R1 irq in reset");
    rst_ni = 1'b1;
    tick();
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset read");
    irq_chk(3'b000, "R1 irq after reset");

    // R2 masks, R3 group enables, R10 global enable
    wr(3'd0, 8'h05);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h80);
    rd_chk(3'd0, 8'h05, "R2 mask0 readback");
    rd_chk(3'd1, 8'h7F, "R2 mask1 bit7 unimplemented");
    rd_chk(3'd2, 8'h80, "R2 mask2 readback");
    wr(3'd3, 8'hFF);
    rd_chk(3'd3, 8'h07, "R3 ctrl reserved bits");
    wr(3'd5, 8'hFF);
    rd_chk(3'd5, 8'h01, "R10 global reserved bits");

    // R4 rising then falling on pin 0
    pins_i[0] = 1'b1; tick();
    irq_chk(3'b001, "R4 rising edge");
    ack_i = 3'b001; tick(); ack_i = '0;
    irq_chk(3'b000, "R8 ack clears");
    pins_i[0] = 1'b0; tick();
    irq_chk(3'b001, "R4 falling edge");
    wr(3'd4, 8'h01);
    irq_chk(3'b000, "R8 write one clears");

    // R5 masked pin and unimplemented pin
    pins_i[1] = 1'b1; tick();
    irq_chk(3'b000, "R5 masked pin");
    pins_i[15] = 1'b1; tick();
    irq_chk(3'b000, "R5 pin 15 unimplemented");
    rd_chk(3'd4, 8'h00, "R5 no flag");

    // group 1 pin 14, write zero keeps flag
    pins_i[14] = 1'b1; tick();
    irq_chk(3'b010, "R4 group1 pin14");
    wr(3'd4, 8'h00);
    irq_chk(3'b010, "R8 write zero no effect");
    wr(3'd4, 8'h02);
    irq_chk(3'b000, "R8 clear group1");

    // R7 global disable
    wr(3'd5, 8'h00);
    pins_i[23] = 1'b1; tick();
    irq_chk(3'b000, "R7 global blocks");
    rd_chk(3'd4, 8'h04, "R7 flag still sets");
    wr(3'd5, 8'h01);
    irq_chk(3'b100, "R7 request after re-enable");
    wr(3'd4, 8'h04);

    // R11 group disabled still records
    wr(3'd3, 8'h06);
    pins_i[0] = 1'b1; tick();
    irq_chk(3'b000, "R11 group disabled");
    rd_chk(3'd4, 8'h01, "R11 flag pending");
    wr(3'd3, 8'h07);
    irq_chk(3'b001, "R11 request after group enable");

    // R9 clear and new change together
    ack_i = 3'b001; pins_i[2] = 1'b1;
    wr(3'd0, 8'h05);
    ack_i = '0;
    irq_chk(3'b001, "R9 set wins over ack");
    pins_i[0] = 1'b0;
    wr(3'd4, 8'h01);
    irq_chk(3'b001, "R9 set wins over write clear");
    wr(3'd4, 8'h01);
    irq_chk(3'b000, "R9 cleared afterwards");

    // R6 independent groups
    pins_i[2] = 1'b0; pins_i[23] = 1'b0; tick();
    irq_chk(3'b101, "R6 two groups");
    wr(3'd3, 8'h04);
    irq_chk(3'b100, "R6 group0 disabled");
    wr(3'd3, 8'h07);
    wr(3'd4, 8'h07);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      pins_i  = pins_i ^ (($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'h0);
      ack_i   = 3'($urandom_range(0, 7)) & {3{($urandom_range(0, 3) == 0)}};
      addr_i  = 3'($urandom_range(0, 7));
      wdata_i = 8'($urandom);
      wr_en_i = ($urandom_range(0, 4) == 0);
      tick();
    end
    wr_en_i = 1'b0; ack_i = '0;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule